// File: doc/BRIEF.md
# SPI Serial Flash Slave Emulator

This block behaves like a small serial NOR flash seen from an SPI host in clock mode 0 (mode 3 is tolerated because only edges are used). A byte array held in registers plays the part of the flash cells. The host lowers chip select and sends a one-byte opcode. Depending on the opcode, address bytes, data bytes, both or neither follow. The block can read, program a page, erase a sector, erase everything, report status, enter and leave a deep power-down state, and return a signature byte.

The SPI pins are brought into the system clock domain through a two-stage synchronizer, and every action is taken on edges detected there. The serial clock must therefore run well below the system clock: each SPI half period must be at least eight system clocks. Program and erase times are simulated by a down-counter whose lengths are parameters. The host polls the busy flag in the status byte to learn when a program or erase has finished.

Top module: `sflash_emu`

## Requirements
- R1: After reset the status byte is 00h, the SPI output is low, and every array byte reads FFh.
- R2: Bits are captured most significant bit first on rising serial clock edges. Output bits change only on falling serial clock edges, with the byte's MSB driven on the first falling edge after the byte that requested it.
- R3: Opcode 03h, followed by a 3-byte address, streams array bytes from that address onward. The address steps by one per byte and wraps from the top of the array to 0. Address bits above the array width are ignored.
- R4: Opcode 05h returns the status byte on every following byte. Bit 0 is the busy flag, bit 1 is the write-enable latch and all other bits are 0. It works while busy.
- R5: Opcode 06h sets the write-enable latch and opcode 04h clears it. Either takes effect only if chip select rises right after the opcode's eighth bit.
- R6: Opcode 02h (page program) is accepted only with the latch set. It ANDs each data byte into the stored byte. It then holds the busy flag for T_PROG system clocks. When busy ends, the latch clears.
- R7: Page program wraps the address inside its 2^PAGE_W-byte page. If more data bytes are sent than the page holds, only the last page-size bytes are written.
- R8: Program and erase commands are discarded with no effect on the array or the latch if chip select rises off a byte boundary. A page program with no data byte is also discarded.
- R9: Opcode D8h followed by a 3-byte address sets the whole 2^SECT_W-byte sector to FFh. It executes only if chip select rises right after the last address byte, and it keeps the block busy for T_SE clocks.
- R10: Opcode C7h sets the whole array to FFh. It executes only if chip select rises right after the opcode, and it keeps the block busy for T_BE clocks.
- R11: While busy, every opcode except 05h is ignored: reads, the signature command, power-down and latch changes. For an ignored command the SPI output stays low, and the running cycle continues unaffected.
- R12: Opcode B9h (taken only when chip select rises right after the opcode) enters deep power-down. In that state every opcode except ABh is ignored, including status reads, which return 00h. Opcode ABh leaves the state when chip select rises, and after three dummy bytes it returns the signature 14h repeatedly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_sck | input | 1 | Serial clock from the host |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host |

## Verification
Program data is tried in several patterns, each aimed at a different fault:
- A byte written onto an erased location, then a second byte ANDed onto it. This shows a true AND rather than an overwrite.
- An 18-byte burst that starts two bytes before the end of its page. The distinct values prove both the in-page wrap and that the two oldest bytes are replaced.
- Transactions cut off a few bits past a byte boundary, which must leave the array and the latch untouched.

Reads are issued with upper address bits set and across the top of the array, which separates correct address truncation and wrap from a stuck or overflowing pointer. Commands sent during a long bulk erase, and while powered down, must be ignored. Later reads of FFh versus 00h and of the latch reveal whether they were.

// File: rtl/sflash_pkg.sv
// Package: opcodes, command codes and the opcode gate shared by the
// emulator. Assumes one opcode byte per transaction.
package sflash_pkg;

    localparam logic [7:0] OPC_WREN = 8'h06;
    localparam logic [7:0] OPC_WRDI = 8'h04;
    localparam logic [7:0] OPC_RDSR = 8'h05;
    localparam logic [7:0] OPC_READ = 8'h03;
    localparam logic [7:0] OPC_PROG = 8'h02;
    localparam logic [7:0] OPC_SERS = 8'hD8;
    localparam logic [7:0] OPC_BERS = 8'hC7;
    localparam logic [7:0] OPC_SLEEP = 8'hB9;
    localparam logic [7:0] OPC_WAKE = 8'hAB;

    typedef enum logic [3:0] {
        CMD_NONE, CMD_STAT, CMD_READ, CMD_PROG, CMD_SERS,
        CMD_BERS, CMD_LSET, CMD_LCLR, CMD_SLEEP, CMD_WAKE
    } sf_cmd_e;

    // Map an opcode to a command, rejecting it when the device state forbids it.
    function automatic sf_cmd_e sf_gate(input logic [7:0] op, input logic busy,
                                        input logic sleep, input logic wel);
        sf_cmd_e c;
        c = CMD_NONE;
        if (sleep) begin
            if (op == OPC_WAKE) c = CMD_WAKE;
        end else if (busy) begin
            if (op == OPC_RDSR) c = CMD_STAT;
        end else begin
            case (op)
                OPC_WREN:  c = CMD_LSET;
                OPC_WRDI:  c = CMD_LCLR;
                OPC_RDSR:  c = CMD_STAT;
                OPC_READ:  c = CMD_READ;
                OPC_PROG:  c = wel ? CMD_PROG : CMD_NONE;
                OPC_SERS:  c = wel ? CMD_SERS : CMD_NONE;
                OPC_BERS:  c = wel ? CMD_BERS : CMD_NONE;
                OPC_SLEEP: c = CMD_SLEEP;
                OPC_WAKE:  c = CMD_WAKE;
                default:   c = CMD_NONE;
            endcase
        end
        return c;
    endfunction

endpackage

// File: rtl/sflash_sync.sv
// Brings chip select, serial clock and data into the system clock domain
// and flags their edges. Assumes each SPI half period spans several clocks.
module sflash_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n_i,
    input  logic sck_i,
    input  logic mosi_i,
    output logic cs_low,
    output logic cs_fall,
    output logic cs_rise,
    output logic sck_rise,
    output logic sck_fall,
    output logic mosi_s
);
    // bit order {cs_n, sck, mosi}
    logic [2:0] st1, st2, st3;

    // Two-flop synchronizer plus one history stage for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st1 <= 3'b100;
            st2 <= 3'b100;
            st3 <= 3'b100;
        end else begin
            st1 <= {cs_n_i, sck_i, mosi_i};
            st2 <= st1;
            st3 <= st2;
        end
    end

    assign cs_low   = ~st2[2];
    assign cs_fall  = ~st2[2] &  st3[2];
    assign cs_rise  =  st2[2] & ~st3[2];
    assign sck_rise =  st2[1] & ~st3[1];
    assign sck_fall = ~st2[1] &  st3[1];
    assign mosi_s   =  st2[0];
endmodule

// File: rtl/sflash_pagebuf.sv
// Staging buffer for one page of program data with a per-byte valid flag.
// Later writes to an offset replace earlier ones, so only the newest
// page-size bytes survive. Cleared at the start of each transaction.
module sflash_pagebuf #(
    parameter int PAGE_W = 4
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             clr,
    input  logic                             wr,
    input  logic [PAGE_W-1:0]                woff,
    input  logic [7:0]                       wdata,
    output logic [(1<<PAGE_W)-1:0][7:0]      pdata,
    output logic [(1<<PAGE_W)-1:0]           pvalid
);
    localparam int PAGE = 1 << PAGE_W;

    for (genvar g = 0; g < PAGE; g++) begin : g_slot
        // Hold one staged byte and whether it was written.
        always_ff @(posedge clk) begin
            if (!rst_n || clr) begin
                pdata[g]  <= 8'hFF;
                pvalid[g] <= 1'b0;
            end else if (wr && woff == PAGE_W'(g)) begin
                pdata[g]  <= wdata;
                pvalid[g] <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/sflash_array.sv
// Register array standing in for flash cells. Erase sets bytes to FFh,
// program ANDs staged bytes into one page. Asynchronous read port.
module sflash_array #(
    parameter int ADDR_W = 8,
    parameter int PAGE_W = 4,
    parameter int SECT_W = 6
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [ADDR_W-1:0]           rd_addr,
    output logic [7:0]                  rd_data,
    input  logic                        prog,
    input  logic [ADDR_W-PAGE_W-1:0]    prog_page,
    input  logic [(1<<PAGE_W)-1:0][7:0] pdata,
    input  logic [(1<<PAGE_W)-1:0]      pvalid,
    input  logic                        sers,
    input  logic [ADDR_W-SECT_W-1:0]    sect,
    input  logic                        bers
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [7:0] mem [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_cell
        localparam logic [ADDR_W-1:0] GA = ADDR_W'(g);
        // Update one cell on erase or program of its page.
        always_ff @(posedge clk) begin
            if (!rst_n || bers)
                mem[g] <= 8'hFF;
            else if (sers && GA[ADDR_W-1:SECT_W] == sect)
                mem[g] <= 8'hFF;
            else if (prog && GA[ADDR_W-1:PAGE_W] == prog_page && pvalid[GA[PAGE_W-1:0]])
                mem[g] <= mem[g] & pdata[GA[PAGE_W-1:0]];
        end
    end

    assign rd_data = mem[rd_addr];
endmodule

// File: rtl/sflash_emu.sv
// SPI serial flash emulator top. Decodes opcode, address and data bytes
// from the synchronized SPI pins, drives the read path, and commits
// program/erase on a chip-select rise at a legal byte count. A down-counter
// models the busy time. Assumes SPI half periods of at least 8 clocks.
module sflash_emu
    import sflash_pkg::*;
#(
    parameter int          ADDR_W = 8,
    parameter int          PAGE_W = 4,
    parameter int          SECT_W = 6,
    parameter int          T_PROG = 64,
    parameter int          T_SE   = 256,
    parameter int          T_BE   = 1024,
    parameter logic [7:0]  SIG    = 8'h14
) (
    input  logic clk,
    input  logic rst_n,
    input  logic spi_cs_n,
    input  logic spi_sck,
    input  logic spi_mosi,
    output logic spi_miso
);
    localparam int T_MAX = (T_BE > T_SE) ? ((T_BE > T_PROG) ? T_BE : T_PROG)
                                         : ((T_SE > T_PROG) ? T_SE : T_PROG);
    localparam int CNT_W = $clog2(T_MAX + 1);
    localparam int PAGE  = 1 << PAGE_W;

    logic cs_low, ev_cs_fall, ev_cs_rise, ev_sck_rise, ev_sck_fall, mosi_s;

    sflash_sync u_sync (
        .clk(clk), .rst_n(rst_n), .cs_n_i(spi_cs_n), .sck_i(spi_sck), .mosi_i(spi_mosi),
        .cs_low(cs_low), .cs_fall(ev_cs_fall), .cs_rise(ev_cs_rise),
        .sck_rise(ev_sck_rise), .sck_fall(ev_sck_fall), .mosi_s(mosi_s)
    );

    logic [2:0]        bit_cnt;
    logic [2:0]        byte_n;     // bytes completed, saturates at 5
    logic [7:0]        rx_sr;
    sf_cmd_e           cmd;
    logic [ADDR_W-1:0] addr_lo;
    logic [ADDR_W-1:0] rd_ptr;
    logic [PAGE_W-1:0] pp_off;
    logic [7:0]        tx_sr;
    logic              miso_q;
    logic              wel_q, dp_q;
    logic [CNT_W-1:0]  busy_cnt;
    logic              busy;

    logic [7:0]        rx_byte;
    logic              byte_done;
    sf_cmd_e           cmd_now;
    logic [ADDR_W-1:0] rd_addr;
    logic [7:0]        rd_data;
    logic [7:0]        tx_next;
    logic [7:0]        status;
    logic              pb_wr;
    logic [PAGE-1:0][7:0] pdata;
    logic [PAGE-1:0]   pvalid;
    logic              aligned, pp_go, se_go, be_go, commit;

    assign busy      = (busy_cnt != '0);
    assign status    = {6'b0, wel_q, busy};
    assign rx_byte   = {rx_sr[6:0], mosi_s};
    assign byte_done = cs_low && ev_sck_rise && bit_cnt == 3'd7;
    assign cmd_now   = (byte_n == 3'd0) ? sf_gate(rx_byte, busy, dp_q, wel_q) : cmd;
    assign rd_addr   = (byte_n == 3'd3) ? ADDR_W'({addr_lo, rx_byte}) : rd_ptr;
    assign pb_wr     = byte_done && cmd == CMD_PROG && byte_n >= 3'd4;

    // Choose the byte to shift out after the byte now completing.
    always_comb begin
        tx_next = 8'h00;
        case (cmd_now)
            CMD_STAT: tx_next = status;
            CMD_READ: if (byte_n >= 3'd3) tx_next = rd_data;
            CMD_WAKE: if (byte_n >= 3'd3) tx_next = SIG;
            default:  tx_next = 8'h00;
        endcase
    end

    // Serial shift-in, byte counting, address capture and shift-out.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt <= '0; byte_n <= '0; rx_sr <= '0; cmd <= CMD_NONE;
            addr_lo <= '0; rd_ptr <= '0; pp_off <= '0; tx_sr <= '0; miso_q <= 1'b0;
        end else if (ev_cs_fall) begin
            bit_cnt <= '0; byte_n <= '0; cmd <= CMD_NONE; pp_off <= '0; tx_sr <= '0;
        end else if (cs_low && ev_sck_rise) begin
            bit_cnt <= bit_cnt + 3'd1;
            rx_sr   <= rx_byte;
            if (bit_cnt == 3'd7) begin
                if (byte_n != 3'd5) byte_n <= byte_n + 3'd1;
                if (byte_n == 3'd0) cmd <= cmd_now;
                if (byte_n >= 3'd1 && byte_n <= 3'd3) addr_lo <= ADDR_W'({addr_lo, rx_byte});
                if (byte_n >= 3'd3) rd_ptr <= rd_addr + 1'b1;
                if (pb_wr) pp_off <= pp_off + 1'b1;
                tx_sr <= tx_next;
            end
        end else if (cs_low && ev_sck_fall) begin
            miso_q <= tx_sr[7];
            tx_sr  <= {tx_sr[6:0], 1'b0};
        end else if (ev_cs_rise) begin
            miso_q <= 1'b0;
            tx_sr  <= '0;
        end
    end

    assign aligned = ev_cs_rise && bit_cnt == 3'd0;
    assign pp_go   = aligned && cmd == CMD_PROG && byte_n == 3'd5;
    assign se_go   = aligned && cmd == CMD_SERS && byte_n == 3'd4;
    assign be_go   = aligned && cmd == CMD_BERS && byte_n == 3'd1;
    assign commit  = pp_go || se_go || be_go;

    // Latch, power-down and busy timer updates at transaction end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wel_q <= 1'b0; dp_q <= 1'b0; busy_cnt <= '0;
        end else begin
            if (busy) begin
                busy_cnt <= busy_cnt - 1'b1;
                if (busy_cnt == CNT_W'(1)) wel_q <= 1'b0;
            end
            if (pp_go) busy_cnt <= CNT_W'(T_PROG);
            if (se_go) busy_cnt <= CNT_W'(T_SE);
            if (be_go) busy_cnt <= CNT_W'(T_BE);
            if (aligned && byte_n == 3'd1 && cmd == CMD_LSET) wel_q <= 1'b1;
            if (aligned && byte_n == 3'd1 && cmd == CMD_LCLR) wel_q <= 1'b0;
            if (aligned && byte_n == 3'd1 && cmd == CMD_SLEEP) dp_q <= 1'b1;
            if (ev_cs_rise && byte_n != 3'd0 && cmd == CMD_WAKE) dp_q <= 1'b0;
        end
    end

    sflash_pagebuf #(.PAGE_W(PAGE_W)) u_pbuf (
        .clk(clk), .rst_n(rst_n), .clr(ev_cs_fall), .wr(pb_wr),
        .woff(addr_lo[PAGE_W-1:0] + pp_off), .wdata(rx_byte),
        .pdata(pdata), .pvalid(pvalid)
    );

    sflash_array #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .SECT_W(SECT_W)) u_array (
        .clk(clk), .rst_n(rst_n), .rd_addr(rd_addr), .rd_data(rd_data),
        .prog(pp_go), .prog_page(addr_lo[ADDR_W-1:PAGE_W]), .pdata(pdata), .pvalid(pvalid),
        .sers(se_go), .sect(addr_lo[ADDR_W-1:SECT_W]), .bers(be_go)
    );

    assign spi_miso = miso_q;
endmodule

// File: rtl/sflash_emu_chk.sv
// Checker for the emulator: relates busy, latch, power-down, commits and
// the SPI output over time. Attached by bind below.
module sflash_emu_chk (
    input logic clk,
    input logic rst_n,
    input logic busy,
    input logic wel,
    input logic dp,
    input logic miso,
    input logic sck_fall,
    input logic cs_rise,
    input logic commit
);
    // R6: a busy period only begins on a chip-select rise
    a_r6_busy_from_cs_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(cs_rise));

    // R6: program/erase commits need the latch and an idle device
    a_r6_commit_needs_wel: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> (wel && !busy));

    // R6: the latch is clear once the busy period ends
    a_r6_wel_clear_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> !wel);

    // R11: power-down is never entered while busy
    a_r11_no_sleep_busy: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dp) |-> !$past(busy));

    // R12: nothing is programmed or erased while powered down
    a_r12_sleep_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        dp |-> !commit);

    // R2: output moves only after a falling serial clock or a deselect
    a_r2_miso_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(miso) |-> ($past(sck_fall) || $past(cs_rise)));
endmodule

bind sflash_emu sflash_emu_chk u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .wel(wel_q), .dp(dp_q),
    .miso(spi_miso), .sck_fall(ev_sck_fall), .cs_rise(ev_cs_rise), .commit(commit)
);

// File: tb/sflash_emu_bench.sv
// Directed bench for the flash emulator: one task per scenario.
module sflash_emu_bench;
    localparam int HALF = 8;
    localparam int TPG  = 600;
    localparam int TSE  = 1000;
    localparam int TBE  = 2000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, sck = 1'b0, mosi = 1'b0;
    logic miso;
    int   n_tests = 0, n_fail = 0;
    logic [7:0] rbuf [0:31];

    always #4 clk = ~clk;

    sflash_emu #(.T_PROG(TPG), .T_SE(TSE), .T_BE(TBE)) u_sflash_emu (
        .clk(clk), .rst_n(rst_n), .spi_cs_n(cs_n), .spi_sck(sck),
        .spi_mosi(mosi), .spi_miso(miso)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic waitc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic sbit(input logic b, output logic r);
        mosi = b;
        waitc(HALF);
        r = miso;
        sck = 1'b1;
        waitc(HALF);
        sck = 1'b0;
    endtask

    task automatic sbyte(input logic [7:0] b, output logic [7:0] r);
        for (int i = 7; i >= 0; i--) sbit(b[i], r[i]);
    endtask

    task automatic cs_on;
        cs_n = 1'b0;
        waitc(HALF);
    endtask

    task automatic cs_off;
        waitc(HALF);
        cs_n = 1'b1;
        waitc(3 * HALF);
    endtask

    task automatic op1(input logic [7:0] op);
        logic [7:0] d;
        cs_on; sbyte(op, d); cs_off;
    endtask

    task automatic rd_stat(output logic [7:0] s0, output logic [7:0] s1);
        logic [7:0] d;
        cs_on; sbyte(8'h05, d); sbyte(8'h00, s0); sbyte(8'h00, s1); cs_off;
    endtask

    task automatic rd_mem(input logic [23:0] a, input int n);
        logic [7:0] d;
        cs_on;
        sbyte(8'h03, d); sbyte(a[23:16], d); sbyte(a[15:8], d); sbyte(a[7:0], d);
        for (int i = 0; i < n; i++) sbyte(8'hFF, rbuf[i]);
        cs_off;
    endtask

    // Program n bytes (base value + index) then optionally extra stray bits.
    task automatic prog(input logic [23:0] a, input int n, input logic [7:0] base,
                        input int extra);
        logic [7:0] d;
        logic r;
        cs_on;
        sbyte(8'h02, d); sbyte(a[23:16], d); sbyte(a[15:8], d); sbyte(a[7:0], d);
        for (int i = 0; i < n; i++) sbyte(base + 8'(i), d);
        for (int i = 0; i < extra; i++) sbit(1'b0, r);
        cs_off;
    endtask

    task automatic t_reset;
        logic [7:0] s0, s1;
        rd_stat(s0, s1);
        chk("R1 status after reset", s0, 8'h00);
        chk("R1 miso idle", {7'b0, miso}, 8'h00);
        rd_mem(24'h000000, 2);
        chk("R1 erased byte 0", rbuf[0], 8'hFF);
        chk("R1 erased byte 1", rbuf[1], 8'hFF);
    endtask

    task automatic t_latch;
        logic [7:0] s0, s1, d;
        logic r;
        op1(8'h06); rd_stat(s0, s1);
        chk("R5 set latch", s0, 8'h02);
        op1(8'h04); rd_stat(s0, s1);
        chk("R5 clear latch", s0, 8'h00);
        cs_on; sbyte(8'h06, d); sbit(1'b0, r); cs_off;
        rd_stat(s0, s1);
        chk("R5 latch set with stray bit ignored", s0, 8'h00);
    endtask

    task automatic t_prog;
        logic [7:0] s0, s1;
        prog(24'h000010, 1, 8'h00, 0); waitc(TPG + 50);
        rd_mem(24'h000010, 1);
        chk("R6 program without latch ignored", rbuf[0], 8'hFF);
        op1(8'h06);
        cs_on; begin logic [7:0] d;
            sbyte(8'h02, d); sbyte(8'h00, d); sbyte(8'h00, d); sbyte(8'h10, d);
            sbyte(8'hA5, d); sbyte(8'h3C, d); end
        cs_off;
        rd_stat(s0, s1);
        chk("R6 busy with latch during program", s0, 8'h03);
        chk("R4 status repeats", s1, 8'h03);
        waitc(TPG + 50);
        rd_stat(s0, s1);
        chk("R6 idle and latch cleared after program", s0, 8'h00);
        rd_mem(24'h000010, 2);
        chk("R2 R6 programmed byte 0", rbuf[0], 8'hA5);
        chk("R6 programmed byte 1", rbuf[1], 8'h3C);
        op1(8'h06); prog(24'h000010, 1, 8'h0F, 0); waitc(TPG + 50);
        rd_mem(24'h000010, 1);
        chk("R6 program ANDs into stored data", rbuf[0], 8'h05);
    endtask

    task automatic t_wrap;
        op1(8'h06); prog(24'h00002E, 18, 8'h40, 0); waitc(TPG + 50);
        rd_mem(24'h000020, 17);
        for (int o = 0; o < 16; o++) begin
            int i;
            i = (o + 2) % 16;
            if (i < 2) i += 16;
            chk("R7 page wrap keeps newest bytes", rbuf[o], 8'h40 + 8'(i));
        end
        chk("R7 next page untouched", rbuf[16], 8'hFF);
    endtask

    task automatic t_misalign;
        logic [7:0] s0, s1, d;
        logic r;
        op1(8'h06); prog(24'h000040, 1, 8'h00, 3);
        rd_stat(s0, s1);
        chk("R8 misaligned program keeps latch, not busy", s0, 8'h02);
        cs_on; sbyte(8'hD8, d); sbyte(8'h00, d); sbyte(8'h00, d); sbyte(8'h10, d);
        sbit(1'b0, r); cs_off;
        cs_on; sbyte(8'hC7, d); sbit(1'b0, r); cs_off;
        prog(24'h000040, 0, 8'h00, 0);
        rd_stat(s0, s1);
        chk("R8 misaligned erases not started", s0, 8'h02);
        rd_mem(24'h000040, 1);
        chk("R8 misaligned program no write", rbuf[0], 8'hFF);
        rd_mem(24'h000010, 1);
        chk("R8 R9 R10 misaligned erase no effect", rbuf[0], 8'h05);
        op1(8'h04);
    endtask

    task automatic t_sector;
        logic [7:0] s0, s1, d;
        op1(8'h06); prog(24'h000050, 1, 8'h11, 0); waitc(TPG + 50);
        op1(8'h06);
        cs_on; sbyte(8'hD8, d); sbyte(8'hFF, d); sbyte(8'h00, d); sbyte(8'h10, d); cs_off;
        rd_stat(s0, s1);
        chk("R9 busy during sector erase", s0, 8'h03);
        waitc(TSE + 50);
        rd_mem(24'h000010, 1);
        chk("R9 sector byte erased", rbuf[0], 8'hFF);
        rd_mem(24'h00002E, 1);
        chk("R9 sector byte erased 2", rbuf[0], 8'hFF);
        rd_mem(24'hE00050, 1);
        chk("R3 R9 upper address ignored, other sector kept", rbuf[0], 8'h11);
    endtask

    task automatic t_rdwrap;
        op1(8'h06); prog(24'h000000, 1, 8'h5A, 0); waitc(TPG + 50);
        rd_mem(24'h0000FF, 2);
        chk("R3 top byte", rbuf[0], 8'hFF);
        chk("R3 read wraps to 0", rbuf[1], 8'h5A);
    endtask

    task automatic t_busy;
        logic [7:0] s0, s1;
        op1(8'h06); op1(8'hC7);
        rd_stat(s0, s1);
        chk("R10 busy during bulk erase", s0, 8'h03);
        rd_mem(24'h000000, 1);
        chk("R11 read ignored while busy", rbuf[0], 8'h00);
        op1(8'hB9);
        waitc(TBE + 100);
        rd_mem(24'h000000, 1);
        chk("R10 R11 bulk erased and no sleep", rbuf[0], 8'hFF);
        rd_mem(24'h000050, 1);
        chk("R10 bulk erase other sector", rbuf[0], 8'hFF);
    endtask

    task automatic t_sleep;
        logic [7:0] s0, s1, d;
        op1(8'h06); op1(8'hB9);
        rd_stat(s0, s1);
        chk("R12 status ignored in sleep", s0, 8'h00);
        prog(24'h000060, 1, 8'h00, 0); waitc(TPG + 50);
        cs_on; sbyte(8'hAB, d); sbyte(8'h00, d); sbyte(8'h00, d); sbyte(8'h00, d);
        sbyte(8'h00, s0); sbyte(8'h00, s1); cs_off;
        chk("R2 R12 signature", s0, 8'h14);
        chk("R12 signature repeats", s1, 8'h14);
        rd_stat(s0, s1);
        chk("R12 awake, latch kept", s0, 8'h02);
        rd_mem(24'h000060, 1);
        chk("R12 program ignored in sleep", rbuf[0], 8'hFF);
        op1(8'h04);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        waitc(5);
        rst_n = 1'b1;
        waitc(5);
        t_reset;
        t_latch;
        t_prog;
        t_wrap;
        t_misalign;
        t_sector;
        t_rdwrap;
        t_busy;
        t_sleep;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule